// File: doc/BRIEF.md
# Sequential Binary-to-BCD Converter

This block turns a 16-bit binary value into packed decimal digits by running a single iterative restoring divider several times in a row, once per decimal place. Each pass divides by a smaller power of ten. The low four bits of that pass's quotient become one digit, and the pass's remainder becomes the dividend for the next pass. The remainder left after the divide-by-ten pass is the units digit.

A conversion starts with a one-cycle `start` strobe while the block is idle. `mode` picks the width and signedness.

- **Word modes** convert all 16 bits. They return four digits on `bcd`. The ten-thousands digit goes into the 4-bit `flags` field.
- **Byte modes** convert only the low byte. They report zero, negative and upper-byte-nonzero conditions in `flags`.
- **Signed modes** negate a negative input (two's complement at the selected width) before dividing, and report the sign on `flags[2]`.

`busy` covers the whole conversion. `done` pulses for one cycle when the result becomes valid.

Top module: `bcd_conv`

## Requirements
- R1: `mode[1]` selects word (1) or byte (0) conversion, and `mode[0]` selects signed (1) or unsigned (0). A `start` seen while idle begins a conversion, and `busy` is high from the next cycle.
- R2: Unsigned word conversion places the thousands digit in `bcd[15:12]`, the hundreds in `bcd[11:8]`, the tens in `bcd[7:4]` and the units in `bcd[3:0]`. The ten-thousands digit is placed in `flags[3:0]`. Example: 0xD431 gives bcd 0x4321 and flags 0x5.
- R3: Byte conversion uses only `din[7:0]`, zero-extended. `bcd[15:8]` holds zero except for the hundreds digit in `bcd[11:8]`, so `bcd[15:12]` is always zero. Example: unsigned 0x00FE gives bcd 0x0254.
- R4: Signed byte conversion negates the value when `din[7]` is 1 and sets `flags[2]` (N) to that sign. Unsigned byte conversion always leaves `flags[2]` at 0. Example: signed 0x00FE gives bcd 0x0002 and flags 0x4.
- R5: Signed word conversion negates the value when `din[15]` is 1. Flags bits 3, 1 and 0 come from the ten-thousands digit, and `flags[2]` is replaced by the sign.
- R6: In byte modes, `flags[0]` (Z) is 1 exactly when the converted result is zero and `flags[1]` (C) is 0. `flags[3]` (O) is 1 when `din[15:8]` is nonzero; it does not change `bcd`.
- R7: `done` is high for exactly one cycle, in the first cycle `busy` is low again. It rises 65 clock edges after the edge that accepted `start` in word modes, and 33 edges after it in byte modes.
- R8: A `start` asserted while `busy` is high is ignored: there is no extra result, no change to the running conversion and no change to its timing.
- R9: Reset clears `bcd`, `flags`, `busy`, `done` and the divider state.
- R10: Each division step yields a quotient of at most 9. The leading word step yields at most 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a conversion when idle |
| mode | input | 2 | [1] word/byte, [0] signed/unsigned |
| din | input | 16 | Binary value to convert |
| bcd | output | 16 | Four packed decimal digits |
| flags | output | 4 | Byte: {O,N,C,Z}; word: ten-thousands digit, bit 2 = sign when signed |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
A divider that keeps a wrong remainder or quotient bit corrupts every later digit. That shows on `bcd` and `flags` at the next `done`, at most 65 cycles after start. Stepping through the divisor sequence wrongly, or counting iterations wrongly, moves `done` away from its fixed 33- or 65-cycle position, so each result is checked for both value and arrival cycle. A mishandled sign or upper-byte test changes a single flag bit, so the stimulus covers negative, most-negative, zero and upper-byte-only inputs.

// File: rtl/bcd_conv.sv
module bcd_conv #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] bcd,
  output logic [3:0]    flags,
  output logic          busy,
  output logic          done
);
  localparam int HW = DW / 2;
  localparam int CW = $clog2(DW);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;
  state_t state;

  logic [DW-1:0] quo, rem, dvsr, nquo, nrem;
  logic [DW:0]   trial, diff;
  logic          ge;
  logic [CW-1:0] cnt;
  logic [1:0]    step;
  logic [3:0]    d4, d3, d2, d1, d0;
  logic          word_q, sgn_q, neg_q, ovf_q;

  logic          in_neg;
  logic [DW-1:0] in_mag;

  always_comb begin
    case (step)
      2'd0:    dvsr = DW'(10000);
      2'd1:    dvsr = DW'(1000);
      2'd2:    dvsr = DW'(100);
      default: dvsr = DW'(10);
    endcase
  end

  assign trial = {rem, quo[DW-1]};
  assign diff  = trial - {1'b0, dvsr};
  assign ge    = trial >= {1'b0, dvsr};
  assign nrem  = ge ? diff[DW-1:0] : trial[DW-1:0];
  assign nquo  = {quo[DW-2:0], ge};

  assign in_neg = mode[0] & (mode[1] ? din[DW-1] : din[HW-1]);
  always_comb begin
    if (mode[1])
      in_mag = in_neg ? (~din + DW'(1)) : din;
    else
      in_mag = {{HW{1'b0}}, in_neg ? (~din[HW-1:0] + HW'(1)) : din[HW-1:0]};
  end

  assign busy = (state != S_IDLE);
  assign bcd  = {d3, d2, d1, d0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      quo    <= '0;
      rem    <= '0;
      cnt    <= '0;
      step   <= '0;
      {d4, d3, d2, d1, d0} <= '0;
      flags  <= '0;
      done   <= 1'b0;
      word_q <= 1'b0;
      sgn_q  <= 1'b0;
      neg_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          quo    <= in_mag;
          rem    <= '0;
          cnt    <= '0;
          step   <= mode[1] ? 2'd0 : 2'd2;
          {d4, d3, d2, d1, d0} <= '0;
          word_q <= mode[1];
          sgn_q  <= mode[0];
          neg_q  <= in_neg;
          ovf_q  <= |din[DW-1:HW];
          state  <= S_RUN;
        end
        S_RUN: if (cnt == CW'(DW-1)) begin
          case (step)
            2'd0: d4 <= nquo[3:0];
            2'd1: d3 <= nquo[3:0];
            2'd2: d2 <= nquo[3:0];
            default: begin
              d1 <= nquo[3:0];
              d0 <= nrem[3:0];
            end
          endcase
          quo  <= nrem;
          rem  <= '0;
          cnt  <= '0;
          step <= step + 2'd1;
          if (step == 2'd3) state <= S_FIN;
        end else begin
          quo <= nquo;
          rem <= nrem;
          cnt <= cnt + CW'(1);
        end
        default: begin
          if (word_q)
            flags <= {d4[3], sgn_q ? neg_q : d4[2], d4[1:0]};
          else
            flags <= {ovf_q, neg_q, 1'b0, ({d2, d1, d0} == 12'd0)};
          done  <= 1'b1;
          state <= S_IDLE;
        end
      endcase
    end
  end

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy); // R1
  AST_BYTE_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !word_q) |-> (bcd[15:12] == 4'd0)); // R3
  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(word_q) && $stable(sgn_q) && $stable(neg_q))); // R8
  AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && cnt == CW'(DW-1)) |-> (nquo <= ((step == 2'd0) ? DW'(6) : DW'(9)))); // R10
endmodule

// File: tb/bcd_conv_test.sv
module bcd_conv_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [15:0] din = '0;
  logic [15:0] bcd;
  logic [3:0]  flags;
  logic        busy, done;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  logic [19:0] exp_q[$];
  int          due_q[$];
  string       req_q[$];

  bcd_conv uut (.clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .din(din),
                .bcd(bcd), .flags(flags), .busy(busy), .done(done));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] model(input logic [1:0] m, input logic [15:0] d);
    int v;
    bit neg;
    logic [3:0] fl;
    logic [15:0] b;
    if (m[1]) begin
      v = d; neg = m[0] && d[15];
      if (neg) v = 65536 - v;
    end else begin
      v = d[7:0]; neg = m[0] && d[7];
      if (neg) v = 256 - v;
    end
    b = {4'((v / 1000) % 10), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
    if (m[1]) begin
      fl = 4'(v / 10000);
      if (m[0]) fl[2] = neg;
    end else
      fl = {|d[15:8], neg, 1'b0, v == 0};
    return {fl, b};
  endfunction

  task automatic convert(input logic [1:0] m, input logic [15:0] d, input string req,
                         input bit poke_busy);
    @(negedge clk);
    start = 1'b1; mode = m; din = d;
    exp_q.push_back(model(m, d));
    due_q.push_back(cyc + 1 + (m[1] ? 65 : 33));
    req_q.push_back(req);
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R1 busy after start", busy, 1);
    if (poke_busy) begin
      repeat (5) @(negedge clk);
      start = 1'b1; mode = ~m; din = ~d;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected done", 1, 0);
      end else begin
        logic [19:0] e;
        int due;
        string r;
        e = exp_q.pop_front(); due = due_q.pop_front(); r = req_q.pop_front();
        check(bcd === e[15:0], {r, " bcd"}, bcd, e[15:0]);
        check(flags === e[19:16], {r, " flags"}, flags, e[19:16]);
        check(cyc == due, "R7 done latency", cyc, due);
      end
    end
  end

  initial begin
    #2_000_000;
    check(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(bcd === 16'h0 && flags === 4'h0 && busy === 1'b0 && done === 1'b0, "R9 reset state",
          {bcd, flags, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    convert(2'b10, 16'hD431, "R2 uword D431", 0);
    convert(2'b10, 16'hFFFF, "R2 uword FFFF", 0);
    convert(2'b10, 16'h0000, "R2 uword 0", 0);
    convert(2'b10, 16'h0009, "R2 uword 9", 0);
    convert(2'b11, 16'hD431, "R5 sword D431", 0);
    convert(2'b11, 16'h8000, "R5 sword 8000", 0);
    convert(2'b11, 16'h7FFF, "R5 sword 7FFF", 0);
    convert(2'b11, 16'hFFFF, "R5 sword FFFF", 0);
    convert(2'b00, 16'h00FE, "R3 ubyte 00FE", 0);
    convert(2'b00, 16'h00FF, "R3 ubyte 00FF", 0);
    convert(2'b00, 16'h1200, "R6 ubyte 1200", 0);
    convert(2'b00, 16'hAB63, "R6 ubyte AB63", 0);
    convert(2'b01, 16'h00FE, "R4 sbyte 00FE", 0);
    convert(2'b01, 16'h0080, "R4 sbyte 0080", 0);
    convert(2'b01, 16'h007F, "R4 sbyte 007F", 0);
    convert(2'b01, 16'hFF00, "R6 sbyte FF00", 0);
    convert(2'b10, 16'h3039, "R8 start ignored while busy word", 1);
    convert(2'b01, 16'h0085, "R8 start ignored while busy byte", 1);
    repeat (80) @(negedge clk);
    check(exp_q.size() == 0, "R8 results outstanding", exp_q.size(), 0);
    @(negedge clk);
    start = 1'b1; mode = 2'b10; din = 16'h1234;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    exp_q.delete(); due_q.delete(); req_q.delete();
    @(negedge clk);
    check(bcd === 16'h0 && flags === 4'h0 && busy === 1'b0 && done === 1'b0, "R9 reset mid-run",
          {bcd, flags, busy, done}, 0);
    rst_n = 1'b1;
    convert(2'b00, 16'h002A, "R9 run after reset", 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule